// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple word-addressed CPU request port to an asynchronous DRAM whose row and column addresses share one set of address pins. Each CPU word address is split in two. The upper half goes out first as the row, qualified by a falling row strobe. After a programmable delay, the lower half follows as the column, qualified by one column strobe per byte lane. A 16-bit transfer pulls both lane strobes low. A single-byte transfer pulls only the strobe of that lane.

The CPU holds `cpu_req` with stable inputs until it sees a one-cycle `cpu_ack`. In the cycle after `cpu_ack` it either drops `cpu_req` or presents the next request. If that next request falls in the row that is already open, the controller keeps the row strobe low and only cycles the column, which gives fast block transfers. Otherwise it closes the row and waits out a precharge time with every strobe high.

A refresh timer raises a pending flag at a fixed interval. Once the current access completes, the pending refresh wins over any waiting CPU request. The refresh is a row-strobe-only cycle on the row held in an internal counter, and that counter steps by one after each refresh.

Top module: `mxdram_ctrl`

## Requirements
- R1: During and right after reset, `dram_ras_n`, all bits of `dram_cas_n` and `dram_we_n` are 1, and `dram_dq_oe` and `cpu_ack` are 0.
- R2: For an access from idle, `dram_ras_n` falls with `cpu_addr[19:10]` on `dram_addr`. Exactly T_RCD cycles later, the column strobes fall with `cpu_addr[9:0]` on `dram_addr`. Column strobes are only ever low while `dram_ras_n` is low.
- R3: Bit i of `cpu_be` selects byte lane i (bit 0 is data bits 7:0, bit 1 is bits 15:8). During the column phase `dram_cas_n[i]` is low exactly for the enabled lanes.
- R4: On a write (`cpu_we`=1), `dram_we_n` is low and `dram_dq_oe` is high during the column phase, with `cpu_wdata` on `dram_dq_o`. A lane whose strobe stays high keeps its stored value.
- R5: `cpu_ack` is a one-cycle pulse. On a read, `cpu_rdata` holds the sampled DRAM word from that cycle on, with the bits of disabled lanes forced to 0.
- R6: A request presented in the cycle after `cpu_ack`, in the same row, with no refresh pending, is served without raising `dram_ras_n`. Its `cpu_ack` comes T_CAS+1 cycles after the previous one, and `dram_addr` does not change while the row is held with all column strobes high.
- R7: Each time `dram_ras_n` falls, it has been high for at least T_RP cycles.
- R8: Every REF_INTERVAL cycles a refresh becomes pending. A refresh holds `dram_ras_n` low for T_RFSH cycles with every column strobe high. It drives the refresh row, which starts at 0 after reset and rises by one after each refresh.
- R9: A pending refresh is run before any waiting CPU request, including in the middle of a same-row burst, which is then resumed with a fresh row opening.
- R10: A request presented to an idle controller is acknowledged T_RCD+T_CAS cycles after the clock edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until acknowledged |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_be | input | 2 | Byte-lane enables, bit 0 is the low byte |
| cpu_addr | input | 20 | Word address; bits 19:10 row, bits 9:0 column |
| cpu_wdata | input | 16 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid from the acknowledge cycle on |
| dram_addr | output | 10 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_o` |
| dram_dq_i | input | 16 | Data returned by the DRAM |

## Verification
The bench builds the controller with T_RCD=3, T_CAS=2, T_RP=3, T_RFSH=4 and REF_INTERVAL=400. These short values make every strobe delay easy to count exactly against a behavioural DRAM model. They also let refreshes come often enough that a 160-word same-row burst is sure to be cut by one, which exercises refresh priority and the row reopening that follows. Address widths stay at 10+10 bits, so row and column extraction is checked on the full 20-bit word address.

// File: rtl/mxdram_pkg.sv
package mxdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PAGE,
    ST_PRE,
    ST_REF
  } seq_st_e;

  typedef enum logic [1:0] {
    AS_ROW,
    AS_COL,
    AS_REF
  } addr_sel_e;

endpackage

// File: rtl/mxdram_refresh_timer.sv
module mxdram_refresh_timer #(
  parameter int INTERVAL = 1560,
  parameter int ROW_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             done,
  output logic             pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      pend    <= 1'b0;
      ref_row <= '0;
    end else begin
      if (tick_q == TW'(INTERVAL - 1)) begin
        tick_q <= '0;
        pend   <= 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
        if (take) pend <= 1'b0;
      end
      if (done) ref_row <= ref_row + 1'b1;
    end
  end

  // R8: refresh row steps by exactly one per completed refresh
  assert_ref_row_step_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  // R8: a pending request is never lost before it is taken
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> pend);

endmodule

// File: rtl/mxdram_addr_mux.sv
module mxdram_addr_mux
  import mxdram_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int PIN_W = 10
) (
  input  addr_sel_e        sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [PIN_W-1:0] pin
);

  always_comb begin
    unique case (sel)
      AS_COL:  pin = PIN_W'(col);
      AS_REF:  pin = PIN_W'(ref_row);
      default: pin = PIN_W'(row);
    endcase
  end

endmodule

// File: rtl/mxdram_seq.sv
module mxdram_seq
  import mxdram_pkg::*;
#(
  parameter int T_RCD  = 6,
  parameter int T_CAS  = 4,
  parameter int T_RP   = 10,
  parameter int T_RFSH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    same_row,
  input  logic    ref_pend,
  output seq_st_e st_nxt,
  output logic    accept,
  output logic    ref_take,
  output logic    ref_done,
  output logic    col_last
);

  localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX_B = (T_RP > T_RFSH) ? T_RP : T_RFSH;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CNT_W  = $clog2(TMAX + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] dur(input seq_st_e s);
    case (s)
      ST_ROW:  dur = CNT_W'(T_RCD - 1);
      ST_COL:  dur = CNT_W'(T_CAS - 1);
      ST_PRE:  dur = CNT_W'(T_RP - 1);
      ST_REF:  dur = CNT_W'(T_RFSH - 1);
      default: dur = '0;
    endcase
  endfunction

  always_comb begin
    st_nxt   = st_q;
    accept   = 1'b0;
    ref_take = 1'b0;
    ref_done = 1'b0;
    col_last = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_nxt   = ST_REF;
          ref_take = 1'b1;
        end else if (req) begin
          st_nxt = ST_ROW;
          accept = 1'b1;
        end
      end
      ST_ROW: if (cnt_q == '0) st_nxt = ST_COL;
      ST_COL: begin
        if (cnt_q == '0) begin
          st_nxt   = ST_PAGE;
          col_last = 1'b1;
        end
      end
      ST_PAGE: begin
        if (req && same_row && !ref_pend) begin
          st_nxt = ST_COL;
          accept = 1'b1;
        end else begin
          st_nxt = ST_PRE;
        end
      end
      ST_PRE: if (cnt_q == '0) st_nxt = ST_IDLE;
      ST_REF: begin
        if (cnt_q == '0) begin
          st_nxt   = ST_PRE;
          ref_done = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_nxt != st_q) cnt_q <= dur(st_nxt);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9: idle with a pending refresh always starts the refresh next
  assert_ref_first_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ref_pend) |=> (st_q == ST_REF));

  // R9: an open row is closed, not reused, while a refresh waits
  assert_ref_first_page_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAGE && ref_pend) |=> (st_q == ST_PRE));

endmodule

// File: rtl/mxdram_ctrl.sv
module mxdram_ctrl
  import mxdram_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 6,
  parameter int T_CAS        = 4,
  parameter int T_RP         = 10,
  parameter int T_RFSH       = 8,
  parameter int REF_INTERVAL = 1560,
  localparam int LANES       = DATA_W / 8,
  localparam int AW          = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [LANES-1:0]  cpu_be,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_i
);

  // latched request
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  // sequencer and timer links
  seq_st_e          st_nxt;
  logic             accept, ref_take, ref_done, col_last;
  logic             ref_pend;
  logic [ROW_W-1:0] ref_row;
  logic             same_row;

  // values effective from the next edge on
  logic [ROW_W-1:0]  row_v;
  logic [COL_W-1:0]  col_v;
  logic              we_v;
  logic [LANES-1:0]  be_v;
  logic [DATA_W-1:0] wdata_v;
  logic              col_nxt, ras_nxt;
  addr_sel_e         sel_nxt;
  logic [PIN_W-1:0]  pin_nxt;
  logic [DATA_W-1:0] lane_mask;

  assign same_row = (cpu_addr[AW-1:COL_W] == row_q);
  assign row_v    = accept ? cpu_addr[AW-1:COL_W] : row_q;
  assign col_v    = accept ? cpu_addr[COL_W-1:0]  : col_q;
  assign we_v     = accept ? cpu_we               : we_q;
  assign be_v     = accept ? cpu_be               : be_q;
  assign wdata_v  = accept ? cpu_wdata            : wdata_q;
  assign col_nxt  = (st_nxt == ST_COL);
  assign ras_nxt  = (st_nxt inside {ST_ROW, ST_COL, ST_PAGE, ST_REF});

  always_comb begin
    unique case (st_nxt)
      ST_COL, ST_PAGE: sel_nxt = AS_COL;
      ST_REF:          sel_nxt = AS_REF;
      default:         sel_nxt = AS_ROW;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_mask[gi*8 +: 8] = {8{be_q[gi]}};
    end
  endgenerate

  mxdram_seq #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP),
    .T_RFSH(T_RFSH)
  ) seq_i (
    .clk     (clk),
    .rst     (rst),
    .req     (cpu_req),
    .same_row(same_row),
    .ref_pend(ref_pend),
    .st_nxt  (st_nxt),
    .accept  (accept),
    .ref_take(ref_take),
    .ref_done(ref_done),
    .col_last(col_last)
  );

  mxdram_refresh_timer #(
    .INTERVAL(REF_INTERVAL),
    .ROW_W   (ROW_W)
  ) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .take   (ref_take),
    .done   (ref_done),
    .pend   (ref_pend),
    .ref_row(ref_row)
  );

  mxdram_addr_mux #(
    .ROW_W(ROW_W),
    .COL_W(COL_W),
    .PIN_W(PIN_W)
  ) amux_i (
    .sel    (sel_nxt),
    .row    (row_v),
    .col    (col_v),
    .ref_row(ref_row),
    .pin    (pin_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q      <= '0;
      col_q      <= '0;
      we_q       <= 1'b0;
      be_q       <= '0;
      wdata_q    <= '0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= '1;
      dram_we_n  <= 1'b1;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      if (accept) begin
        row_q   <= row_v;
        col_q   <= col_v;
        we_q    <= we_v;
        be_q    <= be_v;
        wdata_q <= wdata_v;
      end
      dram_addr  <= pin_nxt;
      dram_ras_n <= !ras_nxt;
      dram_cas_n <= ~(be_v & {LANES{col_nxt}});
      dram_we_n  <= !(col_nxt && we_v);
      dram_dq_oe <= col_nxt && we_v;
      dram_dq_o  <= wdata_v;
      cpu_ack    <= col_last;
      if (col_last) cpu_rdata <= dram_dq_i & lane_mask;
    end
  end

  // precharge window counter for the R7 check
  localparam int HI_W = $clog2(T_RP + 1) + 1;
  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= HI_W'(T_RP);
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt < HI_W'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= HI_W'(T_RP)));

  assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (rst)
    !(&dram_cas_n) |-> !dram_ras_n);

  assert_lane_select_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(&dram_cas_n) && !(&dram_cas_n)) |-> (~dram_cas_n == be_q));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  assert_open_row_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && $past(!dram_ras_n) && (&dram_cas_n) && $past(&dram_cas_n))
      |-> $stable(dram_addr));

  assert_drive_only_write_R4: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_we_n && !(&dram_cas_n)));

endmodule

// File: tb/mxdram_ctrl_tb_top.sv
module mxdram_ctrl_tb_top;

  localparam int ROW_W = 10, COL_W = 10, DATA_W = 16;
  localparam int T_RCD = 3, T_CAS = 2, T_RP = 3, T_RFSH = 4, REF_INTERVAL = 400;
  localparam int LANES = 2, AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [LANES-1:0]  cpu_be = '0;
  logic [AW-1:0]     cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ack;
  logic [DATA_W-1:0] cpu_rdata;
  logic [9:0]        dram_addr;
  logic              dram_ras_n, dram_we_n, dram_dq_oe;
  logic [LANES-1:0]  dram_cas_n;
  logic [DATA_W-1:0] dram_dq_o;
  logic [DATA_W-1:0] dram_dq_i = '0;

  mxdram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RFSH(T_RFSH), .REF_INTERVAL(REF_INTERVAL)
  ) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural DRAM model ----------------
  logic [15:0] mem [int unsigned];
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  logic [LANES-1:0] lanes_last = '0;
  bit ras_prev = 1'b1, cas_prev_hi = 1'b1, cas_seen = 1'b0;
  int fall_cyc = 0, rcd_last = 0, ras_falls = 0;
  int hi_run = 1000, hi_last = 0, low_run = 0, ref_low_last = 0, ref_cnt = 0;
  int ref_rows[$];

  function automatic logic [15:0] mem_rd(input int unsigned k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      ras_prev = 1'b1; cas_prev_hi = 1'b1; hi_run = 1000;
    end else begin
      int unsigned k;
      logic [15:0] w;
      if (ras_prev && !dram_ras_n) begin
        hi_last = hi_run; row_l = dram_addr[ROW_W-1:0]; fall_cyc = cyc;
        ras_falls++; cas_seen = 1'b0; low_run = 0;
      end
      if (dram_ras_n) hi_run++;
      else begin hi_run = 0; low_run++; end
      if (!dram_ras_n && cas_prev_hi && !(&dram_cas_n)) begin
        col_l = dram_addr[COL_W-1:0]; rcd_last = cyc - fall_cyc;
        lanes_last = ~dram_cas_n; cas_seen = 1'b1;
      end
      k = {12'd0, row_l, dram_addr[COL_W-1:0]};
      if (!dram_ras_n && !(&dram_cas_n) && !dram_we_n) begin
        w = mem_rd(k);
        if (!dram_cas_n[0]) w[7:0]  = dram_dq_o[7:0];
        if (!dram_cas_n[1]) w[15:8] = dram_dq_o[15:8];
        mem[k] = w;
      end
      if (!dram_ras_n && !(&dram_cas_n) && dram_we_n) dram_dq_i <= mem_rd(k);
      if (!ras_prev && dram_ras_n && !cas_seen) begin
        ref_cnt++; ref_rows.push_back(int'(row_l)); ref_low_last = low_run;
      end
      ras_prev = dram_ras_n; cas_prev_hi = &dram_cas_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic access(input logic [AW-1:0] a, input bit we, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    int start;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
    start = cyc;
    do @(negedge clk); while (!cpu_ack);
    lat = cyc - start;
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic sync_ref();
    int r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    repeat (T_RP + 2) @(negedge clk);
  endtask

  task automatic burst(input logic [ROW_W-1:0] row, input int col0, input int n,
                       input bit we, input logic [15:0] base, input bit chk_gap,
                       input string req);
    int last_ack = 0, bad_gap = 0, bad_data = 0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      cpu_req = 1'b1; cpu_we = we; cpu_be = 2'b11;
      cpu_addr = {row, COL_W'(col0 + i)}; cpu_wdata = base + 16'(i);
      do @(negedge clk); while (!cpu_ack);
      if (i > 0 && (cyc - last_ack) != T_CAS + 1) bad_gap++;
      if (!we && cpu_rdata != base + 16'(i)) bad_data++;
      last_ack = cyc;
    end
    cpu_req = 1'b0;
    if (chk_gap) chk(bad_gap == 0, req, "page ack spacing violations", bad_gap, 0);
    if (!we) chk(bad_data == 0, req, "burst read mismatches", bad_data, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(dram_ras_n && (&dram_cas_n) && dram_we_n, "R1", "strobes idle after reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 4'hF);
    chk(!dram_dq_oe && !cpu_ack, "R1", "oe/ack low after reset", {dram_dq_oe, cpu_ack}, 0);
  endtask

  task automatic t_first_write();
    logic [15:0] rd; int lat;
    access({10'h2C3, 10'h1A5}, 1'b1, 2'b11, 16'hBEEF, rd, lat);
    chk(lat == T_RCD + T_CAS + 1, "R10", "idle ack latency", lat, T_RCD + T_CAS + 1);
    chk(row_l == 10'h2C3, "R2", "row on pins at row strobe", row_l, 10'h2C3);
    chk(col_l == 10'h1A5, "R2", "column on pins at column strobe", col_l, 10'h1A5);
    chk(rcd_last == T_RCD, "R2", "row-to-column cycles", rcd_last, T_RCD);
    chk(mem_rd({12'd0, 10'h2C3, 10'h1A5}) == 16'hBEEF, "R4", "word stored",
        mem_rd({12'd0, 10'h2C3, 10'h1A5}), 16'hBEEF);
  endtask

  task automatic t_read_and_lanes();
    logic [15:0] rd; int lat;
    sync_ref();
    access({10'h2C3, 10'h1A5}, 1'b0, 2'b11, 16'h0, rd, lat);
    chk(rd == 16'hBEEF, "R5", "full-word read", rd, 16'hBEEF);
    @(negedge clk);
    chk(!cpu_ack, "R5", "ack single cycle", cpu_ack, 0);
    access({10'h011, 10'h022}, 1'b1, 2'b11, 16'hAAAA, rd, lat);
    access({10'h011, 10'h022}, 1'b1, 2'b01, 16'h1234, rd, lat);
    chk(lanes_last == 2'b01, "R3", "only low lane strobe", lanes_last, 2'b01);
    chk(mem_rd({12'd0, 10'h011, 10'h022}) == 16'hAA34, "R4", "high lane kept",
        mem_rd({12'd0, 10'h011, 10'h022}), 16'hAA34);
    access({10'h011, 10'h022}, 1'b0, 2'b10, 16'h0, rd, lat);
    chk(lanes_last == 2'b10, "R3", "only high lane strobe", lanes_last, 2'b10);
    chk(rd == 16'hAA00, "R5", "disabled lane reads zero", rd, 16'hAA00);
  endtask

  task automatic t_page();
    int f0;
    sync_ref();
    f0 = ras_falls;
    burst(10'h155, 4, 4, 1'b1, 16'h5000, 1'b1, "R6");
    chk(ras_falls - f0 == 1, "R6", "single row opening for write burst", ras_falls - f0, 1);
    f0 = ras_falls;
    burst(10'h155, 4, 4, 1'b0, 16'h5000, 1'b1, "R6");
    chk(ras_falls - f0 == 1, "R6", "single row opening for read burst", ras_falls - f0, 1);
  endtask

  task automatic t_row_change();
    logic [15:0] rd; int lat;
    sync_ref();
    access({10'h005, 10'h001}, 1'b1, 2'b11, 16'h0505, rd, lat);
    access({10'h006, 10'h001}, 1'b1, 2'b11, 16'h0606, rd, lat);
    chk(row_l == 10'h006, "R7", "new row opened", row_l, 10'h006);
    chk(hi_last >= T_RP, "R7", "precharge cycles before reopen", hi_last, T_RP);
  endtask

  task automatic t_refresh();
    int bad = 0;
    while (ref_cnt < 4) @(negedge clk);
    for (int i = 0; i < ref_rows.size(); i++) if (ref_rows[i] != i) bad++;
    chk(bad == 0, "R8", "refresh rows count up from zero", bad, 0);
    chk(ref_low_last == T_RFSH, "R8", "refresh strobe width", ref_low_last, T_RFSH);
  endtask

  task automatic t_priority();
    int r0, f0;
    sync_ref();
    r0 = ref_cnt; f0 = ras_falls;
    burst(10'h02A, 100, 160, 1'b1, 16'h7000, 1'b0, "R9");
    chk(ref_cnt > r0, "R9", "refresh ran inside long burst", ref_cnt - r0, 1);
    chk(ras_falls - f0 >= 3, "R9", "row reopened after refresh", ras_falls - f0, 3);
    burst(10'h02A, 100, 160, 1'b0, 16'h7000, 1'b0, "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_write();
    t_read_and_lanes();
    t_page();
    t_row_change();
    t_refresh();
    t_priority();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule